// File: doc/BRIEF.md
# Single-Cycle Integer Core (RV32 ALU and Word-Memory Subset)

The block is a small processor that fetches, executes and retires one instruction on every rising clock edge. A byte-addressed program counter indexes a constant instruction ROM by word. Each instruction's fields are decoded in two steps. A class decoder looks at the 7-bit opcode and sets the operand source, the write-back source and the enables for the register file and data memory. It also emits a 2-bit ALU class. An operation decoder then combines that class with funct3 and one funct7 bit to pick the ALU function.

Operands come from a 32-entry register file, and the second operand can instead come from a sign-extended immediate. A word-wide data memory serves loads and stores. The ALU output of the instruction being executed is driven onto the single result port in every cycle, so for a load or store the port shows the effective address. The only other inputs are the clock and a synchronous active-low reset.

Top module: `rv_lite_core`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter is cleared to 0, so the result port shows the outcome of ROM word 0.
- R2: Every cycle out of reset, the PC grows by 4 and wraps modulo 256. The ROM is read at word index PC[7:2], so after 64 cycles the program restarts at word 0.
- R3: Opcode 0110011 takes its second operand from rs2, and opcodes 0010011, 0000011 and 0100011 take it from the immediate. Every supported opcode writes the register file except store (0100011), which writes memory and leaves every register unchanged.
- R4: Opcode 0110011 is ALU class 10, 0010011 is class 00, and loads and stores are class 01. ALU function codes are AND=0000, OR=0001, ADD=0010, SUB=0110, SLT=0111, NOR=1100. Class 01 always selects ADD.
- R5: funct3 picks the function: 000 is ADD (SUB only in class 10 with funct7 bit 5 set), 111 is AND, 110 is OR, 010 is signed SLT, and 100 is NOR. In class 00, instruction bit 30 is part of the immediate and never selects SUB.
- R6: Immediates for opcodes 0010011 and 0000011 are instruction bits [31:20], sign-extended. For stores the immediate is {bits[31:25], bits[11:7]}, sign-extended.
- R7: Register x0 always reads as zero, and writes to it are discarded.
- R8: A store writes rs2 to data-memory word ALU[8:2], and a later load from the same address returns that word to rd.
- R9: The result port equals the ALU output of the instruction being executed in the current cycle, for every instruction class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| result | output | 32 | ALU output of the current instruction |

## Verification
The bench builds the core with its default parameters: an 8-bit PC, 32-bit data, 32 registers and a 9-bit data address. With these values the 64-word ROM is small enough that the bench can step through all of it. This lets it see the PC wrap back to word 0 and the idle filler words that write x0.

The built-in program covers a negative SUB result and signed SLT in both directions. It also checks an ADDI whose bit 30 is set, so that the instruction must not turn into a subtract. Other cases are a store whose rd-position bits alias a live register, a load that returns a stored word, and a store and load with a negative offset.

// File: rtl/rv_lite_pkg.sv
// Package: shared encodings and the built-in program for rv_lite_core.
// Assumes: 32-bit instructions; ROM index is the word address of the PC.
package rv_lite_pkg;

    localparam logic [6:0] OPC_RR   = 7'b0110011;
    localparam logic [6:0] OPC_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_LOAD = 7'b0000011;
    localparam logic [6:0] OPC_STOR = 7'b0100011;

    typedef enum logic [1:0] {
        CLS_IMM = 2'b00,
        CLS_MEM = 2'b01,
        CLS_RR  = 2'b10
    } alu_cls_e;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    localparam logic [2:0] F3_ADD = 3'b000;
    localparam logic [2:0] F3_SLT = 3'b010;
    localparam logic [2:0] F3_NOR = 3'b100;
    localparam logic [2:0] F3_OR  = 3'b110;
    localparam logic [2:0] F3_AND = 3'b111;

    // Build a register-register instruction word
    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, OPC_RR};
    endfunction

    // Build an immediate-format (ALU or load) instruction word
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    // Build a word-store instruction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1);
        return {imm[11:5], rs2, rs1, F3_SLT, imm[4:0], OPC_STOR};
    endfunction

    // Constant program; unused words are addi x0,x0,0
    function automatic logic [31:0] prog_word(input int unsigned idx);
        case (idx)
            0:  return enc_i(12'h005, 5'd0, F3_ADD, 5'd1, OPC_IMM);
            1:  return enc_i(12'hFFD, 5'd0, F3_ADD, 5'd2, OPC_IMM);
            2:  return enc_r(7'h00, 5'd2, 5'd1, F3_ADD, 5'd3);
            3:  return enc_r(7'h20, 5'd1, 5'd2, F3_ADD, 5'd4);
            4:  return enc_r(7'h00, 5'd2, 5'd1, F3_AND, 5'd5);
            5:  return enc_r(7'h00, 5'd2, 5'd1, F3_OR,  5'd6);
            6:  return enc_r(7'h00, 5'd1, 5'd2, F3_SLT, 5'd7);
            7:  return enc_r(7'h00, 5'd2, 5'd1, F3_SLT, 5'd8);
            8:  return enc_r(7'h00, 5'd2, 5'd1, F3_NOR, 5'd9);
            9:  return enc_i(12'h0F0, 5'd2, F3_AND, 5'd10, OPC_IMM);
            10: return enc_i(12'h700, 5'd1, F3_OR,  5'd11, OPC_IMM);
            11: return enc_i(12'hFF0, 5'd1, F3_NOR, 5'd12, OPC_IMM);
            12: return enc_i(12'h004, 5'd2, F3_SLT, 5'd13, OPC_IMM);
            13: return enc_s(12'h004, 5'd4, 5'd10);
            14: return enc_i(12'h004, 5'd10, F3_SLT, 5'd14, OPC_LOAD);
            15: return enc_r(7'h00, 5'd4, 5'd14, F3_ADD, 5'd15);
            16: return enc_i(12'h007, 5'd1, F3_ADD, 5'd0, OPC_IMM);
            17: return enc_r(7'h00, 5'd1, 5'd0, F3_ADD, 5'd16);
            18: return enc_i(12'h400, 5'd1, F3_ADD, 5'd18, OPC_IMM);
            19: return enc_s(12'hFFC, 5'd1, 5'd10);
            20: return enc_i(12'hFFC, 5'd10, F3_SLT, 5'd19, OPC_LOAD);
            21: return enc_r(7'h00, 5'd19, 5'd19, F3_ADD, 5'd20);
            default: return enc_i(12'h000, 5'd0, F3_ADD, 5'd0, OPC_IMM);
        endcase
    endfunction

endpackage

// File: rtl/rv_lite_class_dec.sv
// Module: opcode class decoder.
// Maps the 7-bit opcode to datapath controls and a 2-bit ALU class.
// Assumes: unknown opcodes disable every write and use class IMM.
module rv_lite_class_dec
    import rv_lite_pkg::*;
(
    input  logic [6:0] opcode,
    output logic       use_imm,
    output logic       wb_from_mem,
    output logic       rf_we,
    output logic       dm_rd,
    output logic       dm_we,
    output alu_cls_e   cls
);

    // Decode opcode into control bundle
    always_comb begin
        use_imm     = 1'b0;
        wb_from_mem = 1'b0;
        rf_we       = 1'b0;
        dm_rd       = 1'b0;
        dm_we       = 1'b0;
        cls         = CLS_IMM;
        case (opcode)
            OPC_RR: begin
                rf_we = 1'b1;
                cls   = CLS_RR;
            end
            OPC_IMM: begin
                use_imm = 1'b1;
                rf_we   = 1'b1;
            end
            OPC_LOAD: begin
                use_imm     = 1'b1;
                wb_from_mem = 1'b1;
                rf_we       = 1'b1;
                dm_rd       = 1'b1;
                cls         = CLS_MEM;
            end
            OPC_STOR: begin
                use_imm = 1'b1;
                dm_we   = 1'b1;
                cls     = CLS_MEM;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rv_lite_op_dec.sv
// Module: ALU operation decoder.
// Combines the ALU class with funct3 and funct7 bit 5 into an ALU function.
// Assumes: alt_bit is meaningful only for register-register instructions.
module rv_lite_op_dec
    import rv_lite_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [2:0] funct3,
    input  logic       alt_bit,
    output alu_op_e    op
);

    // Select ALU function
    always_comb begin
        if (cls == CLS_MEM) begin
            op = OP_ADD;
        end else begin
            case (funct3)
                F3_ADD:  op = (cls == CLS_RR && alt_bit) ? OP_SUB : OP_ADD;
                F3_AND:  op = OP_AND;
                F3_OR:   op = OP_OR;
                F3_SLT:  op = OP_SLT;
                F3_NOR:  op = OP_NOR;
                default: op = OP_ADD;
            endcase
        end
    end

endmodule

// File: rtl/rv_lite_regfile.sv
// Module: two-read, one-write register file.
// Reads are combinational; the write lands on the rising edge.
// Assumes: entry 0 reads as zero and is never written.
module rv_lite_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs [NREG];

    // Write port, register 0 excluded
    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Read ports with hard-wired zero register
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end

    // R7
    x0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0));

endmodule

// File: rtl/rv_lite_alu.sv
// Module: integer ALU.
// Computes AND, OR, ADD, SUB, signed set-less-than and NOR.
// Assumes: unlisted codes yield zero.
module rv_lite_alu
    import rv_lite_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    // Evaluate selected function
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rv_lite_core.sv
// Module: single-cycle core top.
// Holds the PC, instruction ROM, immediate generator and data memory,
// and drives the ALU output of each instruction onto result.
// Assumes: word-aligned data addresses; ROM contents come from the package.
module rv_lite_core
    import rv_lite_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int DM_AW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] result
);

    localparam int RAW      = $clog2(NREG);
    localparam int DM_WORDS = 2 ** (DM_AW - 2);

    logic [PC_W-1:0] pc;
    logic [31:0]     instr;
    logic            use_imm, wb_from_mem, rf_we, dm_rd, dm_we;
    alu_cls_e        cls;
    alu_op_e         alu_op;
    logic [XLEN-1:0] rs1_val, rs2_val, imm, opnd_b, alu_y, dm_q, wb_val;
    logic [XLEN-1:0] dmem [DM_WORDS];
    logic [1:0]      unused_pc_lsb;

    assign unused_pc_lsb = pc[1:0];

    // Program counter: clear on reset, else step one word
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + PC_W'(4);
    end

    // Instruction fetch from constant ROM
    always_comb instr = prog_word(int'(pc[PC_W-1:2]));

    rv_lite_class_dec u_cdec (
        .opcode      (instr[6:0]),
        .use_imm     (use_imm),
        .wb_from_mem (wb_from_mem),
        .rf_we       (rf_we),
        .dm_rd       (dm_rd),
        .dm_we       (dm_we),
        .cls         (cls)
    );

    rv_lite_op_dec u_odec (
        .cls     (cls),
        .funct3  (instr[14:12]),
        .alt_bit (instr[30]),
        .op      (alu_op)
    );

    rv_lite_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[15 +: RAW]),
        .ra2   (instr[20 +: RAW]),
        .we    (rf_we),
        .wa    (instr[7 +: RAW]),
        .wd    (wb_val),
        .rd1   (rs1_val),
        .rd2   (rs2_val)
    );

    // Immediate generation: store split field or I-type field
    always_comb begin
        if (dm_we) imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
        else       imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
    end

    // Second operand select
    always_comb opnd_b = use_imm ? imm : rs2_val;

    rv_lite_alu #(.XLEN(XLEN)) u_alu (
        .op (alu_op),
        .a  (rs1_val),
        .b  (opnd_b),
        .y  (alu_y)
    );

    // Data memory write port, word-indexed
    always_ff @(posedge clk) begin
        if (dm_we) dmem[alu_y[DM_AW-1:2]] <= rs2_val;
    end

    // Data memory read and write-back select
    always_comb begin
        dm_q   = dm_rd ? dmem[alu_y[DM_AW-1:2]] : '0;
        wb_val = wb_from_mem ? dm_q : alu_y;
    end

    assign result = alu_y;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pc == $past(pc) + PC_W'(4)));

    // R3
    store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we);

    // R4
    mem_class_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_MEM) |-> (alu_op == OP_ADD));

    // R5
    sub_regreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == OP_SUB) |-> (cls == CLS_RR));

endmodule

// File: tb/rv_lite_core_tb.sv
module rv_lite_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] result;
    int          n_chk = 0;
    int          n_bad = 0;
    int          wd_hit = 0;

    rv_lite_core u_dut (.clk(clk), .rst_n(rst_n), .result(result));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected ALU output of each program word, worked out by hand
    function automatic logic [31:0] exp_at(input int i);
        case (i)
            0: return 32'h5;          1: return 32'hFFFF_FFFD;
            2: return 32'h2;          3: return 32'hFFFF_FFF8;
            4: return 32'h5;          5: return 32'hFFFF_FFFD;
            6: return 32'h1;          7: return 32'h0;
            8: return 32'h2;          9: return 32'hF0;
            10: return 32'h705;       11: return 32'hA;
            12: return 32'h1;         13: return 32'hF4;
            14: return 32'hF4;        15: return 32'hFFFF_FFF0;
            16: return 32'hC;         17: return 32'h5;
            18: return 32'h405;       19: return 32'hEC;
            20: return 32'hEC;        21: return 32'hA;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] exp, input string rq);
        #1;
        n_chk++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: result=%h expected=%h", rq, result, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(exp_at(0), "R1");
        rst_n = 1'b1;
        chk(exp_at(0), "R9");
    endtask

    task automatic t_reg_ops();
        for (int i = 1; i <= 8; i++) begin
            step();
            chk(exp_at(i), (i == 3) ? "R4" : "R5");
        end
    endtask

    task automatic t_imm_ops();
        for (int i = 9; i <= 12; i++) begin
            step();
            chk(exp_at(i), (i == 11) ? "R6" : "R5");
        end
    endtask

    task automatic t_mem_ops();
        step(); chk(exp_at(13), "R8");
        step(); chk(exp_at(14), "R8");
        step(); chk(exp_at(15), "R3");
    endtask

    task automatic t_zero_reg();
        step(); chk(exp_at(16), "R9");
        step(); chk(exp_at(17), "R7");
        step(); chk(exp_at(18), "R5");
    endtask

    task automatic t_neg_offset();
        step(); chk(exp_at(19), "R6");
        step(); chk(exp_at(20), "R8");
        step(); chk(exp_at(21), "R8");
    endtask

    task automatic t_wrap();
        for (int i = 22; i < 64; i++) begin
            step();
            chk(32'h0, "R2");
        end
        step();
        chk(exp_at(0), "R2");
        step();
        chk(exp_at(1), "R2");
    endtask

    task automatic t_reset_mid();
        step();
        step();
        chk(exp_at(3), "R2");
        rst_n = 1'b0;
        step();
        chk(exp_at(0), "R1");
        rst_n = 1'b1;
        step();
        chk(exp_at(1), "R1");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        wd_hit = 1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: result=%h expected=finish", result);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_reg_ops();
        t_imm_ops();
        t_mem_ops();
        t_zero_reg();
        t_neg_offset();
        t_wrap();
        t_reset_mid();
        if (wd_hit == 0) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule